// File: doc/BRIEF.md
# Page Translation Cache with Global Entry Retention

This block is a small fully associative cache of address translations. Each entry maps a 20-bit virtual page number to a 20-bit physical frame number and carries a writable flag and a global flag. A lookup is answered in the same cycle, with a hit indication, the frame and the writable flag. After a page walk completes, its result is written in through the fill port. One module serves both instruction fetch and data accesses; a core builds two instances of it.

Three controls remove entries. A page-directory base reload and a task-switch strobe both flush the cache. When the global-enable input is high, a flush keeps the entries marked global. A single-page invalidate names one virtual page and removes that entry whatever its global flag. A fill picks its slot in a fixed order. It first reuses a valid entry that has the same page number. If there is none, it takes the lowest-index free slot. If the cache is full, it replaces the slot named by a round-robin pointer.

The lookup and fill inputs are qualified by a valid strobe each, and there is no back-pressure. A lookup is combinational, and the block accepts every fill in the cycle it is presented. The flush and invalidate inputs are plain single-cycle strobes.

Top module: `xc_tlb`

## Requirements
- R1: After reset every entry is invalid and every lookup misses.
- R2: A lookup is combinational. On a hit, `lk_hit` is 1 and `lk_pfn` and `lk_writable` show the matching entry in the same cycle. On a miss, `lk_hit` is 0 and both `lk_pfn` and `lk_writable` read as 0.
- R3: A fill presented in one cycle is visible to lookups from the next cycle onward.
- R4: A fill whose page number matches a valid entry overwrites that entry, so no duplicate is created.
- R5: A fill with no matching entry goes to the lowest-index invalid entry when one exists.
- R6: With all entries valid, a new fill replaces the entry at a round-robin pointer. The pointer starts at index 0 after reset and advances by one, wrapping modulo the depth of 8, only on such a replacement.
- R7: A base reload (`base_load`) with `glob_en` low invalidates every entry, including the global ones.
- R8: A base reload with `glob_en` high invalidates only the entries whose global flag is 0.
- R9: A `task_switch` strobe flushes exactly as a base reload does, under both settings of `glob_en`.
- R10: A single-page invalidate removes only the entry that matches `inv_vpn`, even when that entry is global.
- R11: When a fill and an invalidation fall in the same cycle, the invalidation is applied first. The filled entry therefore survives, and it takes the lowest slot that the invalidation freed.
- R12: With `lk_valid` low, `lk_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Frame for the lookup (0 on a miss) |
| lk_writable | output | 1 | Writable flag for the lookup (0 on a miss) |
| fill_valid | input | 1 | Fill strobe, always accepted |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | 20 | Fill physical frame number |
| fill_global | input | 1 | Fill marks the entry global |
| fill_writable | input | 1 | Fill writable flag |
| base_load | input | 1 | Directory base register reload strobe |
| task_switch | input | 1 | Task switch strobe (implicit base reload) |
| inv_valid | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 20 | Page number to invalidate |
| glob_en | input | 1 | Global entries survive flushes when high |

## Verification
A fill can land in the same cycle as an invalidation, and that collision is what the tests aim at. The bench raises a base reload together with a fill of a new page. It also raises a single-page invalidate together with a refill of the same page that carries a different frame. In the following cycle it judges the result at the lookup port. The filled page must hit with the new frame, and every flushed page must miss. In a separate test a free-slot fill and a round-robin fill are interleaved, and the order in which pages are evicted confirms that the invalidation freed a slot and that the fill took it.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             glob;
    logic             wr;
  } xc_payload_t;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 20,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][KEY_W-1:0] tags,
  input  logic [KEY_W-1:0]            key,
  output logic [DEPTH-1:0]            hitv,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitv[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |hitv;

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitv[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] valid,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] idx,
  output logic             use_ptr
);
  logic             any_free;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign use_ptr = !any_free;
  assign idx     = any_free ? free_idx : ptr;
endmodule

// File: rtl/xc_store.sv
module xc_store
  import xc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            keep,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  xc_payload_t                 wr_data,
  input  logic                        adv_ptr,
  output logic [DEPTH-1:0]            valid_q,
  output logic [DEPTH-1:0][VPN_W-1:0] vpn_q,
  output xc_payload_t [DEPTH-1:0]     data_q,
  output logic [IDX_W-1:0]            ptr_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else begin
        valid_q[g] <= keep[g] | sel;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q[g]  <= wr_vpn;
        data_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv_ptr) begin
      ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xc_tlb.sv
module xc_tlb
  import xc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_writable,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_global,
  input  logic             fill_writable,
  input  logic             base_load,
  input  logic             task_switch,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             glob_en
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][VPN_W-1:0] vpn_q;
  xc_payload_t [DEPTH-1:0]     data_q;
  logic [IDX_W-1:0]            ptr_q;
  logic [DEPTH-1:0]            glob_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_glob
    assign glob_q[g] = data_q[g].glob;
  end

  // Lookup path
  logic [DEPTH-1:0] lk_hitv;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;

  xc_match #(.DEPTH(DEPTH), .KEY_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(vpn_q), .key(lk_vpn),
    .hitv(lk_hitv), .hit(lk_any), .idx(lk_idx)
  );

  assign lk_hit      = lk_valid && lk_any;
  assign lk_pfn      = lk_hit ? data_q[lk_idx].pfn : '0;
  assign lk_writable = lk_hit && data_q[lk_idx].wr;

  // Invalidation is resolved before the fill
  logic [DEPTH-1:0] inv_hitv;
  logic             inv_any;
  logic [IDX_W-1:0] inv_idx;

  xc_match #(.DEPTH(DEPTH), .KEY_W(VPN_W)) u_inv_match (
    .valid(valid_q), .tags(vpn_q), .key(inv_vpn),
    .hitv(inv_hitv), .hit(inv_any), .idx(inv_idx)
  );

  logic             flush;
  logic [DEPTH-1:0] flush_keep;
  logic [DEPTH-1:0] keep;

  assign flush      = base_load || task_switch;
  assign flush_keep = !flush ? '1 : (glob_en ? glob_q : '0);
  assign keep       = valid_q & flush_keep & ~(inv_valid ? inv_hitv : '0);

  // Fill placement against surviving entries
  logic [DEPTH-1:0] fill_hitv;
  logic             fill_hit;
  logic [IDX_W-1:0] fill_hidx;
  logic [IDX_W-1:0] vic_idx;
  logic             vic_use_ptr;

  xc_match #(.DEPTH(DEPTH), .KEY_W(VPN_W)) u_fill_match (
    .valid(keep), .tags(vpn_q), .key(fill_vpn),
    .hitv(fill_hitv), .hit(fill_hit), .idx(fill_hidx)
  );

  xc_victim #(.DEPTH(DEPTH)) u_victim (
    .valid(keep), .ptr(ptr_q), .idx(vic_idx), .use_ptr(vic_use_ptr)
  );

  logic [IDX_W-1:0] wr_idx;
  logic             adv_ptr;
  xc_payload_t      wr_data;

  assign wr_idx       = fill_hit ? fill_hidx : vic_idx;
  assign adv_ptr      = fill_valid && !fill_hit && vic_use_ptr;
  assign wr_data.pfn  = fill_pfn;
  assign wr_data.glob = fill_global;
  assign wr_data.wr   = fill_writable;

  xc_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .keep(keep),
    .wr_en(fill_valid), .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_data(wr_data),
    .adv_ptr(adv_ptr),
    .valid_q(valid_q), .vpn_q(vpn_q), .data_q(data_q), .ptr_q(ptr_q)
  );
endmodule

// File: rtl/xc_tlb_chk.sv
module xc_tlb_chk #(
  parameter int DEPTH = 8,
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             base_load,
  input logic             task_switch,
  input logic             inv_valid,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             glob_en,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] glob_q,
  input logic [DEPTH-1:0] lk_hitv
);
  // R12
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);

  // R4
  no_dup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hitv));

  // R3
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (!(lk_valid && lk_vpn == $past(fill_vpn)) || lk_hit));

  // R7
  full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_load && !glob_en && !fill_valid) |=> (valid_q == '0));

  // R8
  glob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((base_load || task_switch) && glob_en && !inv_valid && !fill_valid)
      |=> ((valid_q & $past(valid_q & glob_q)) == $past(valid_q & glob_q)));

  // R10
  page_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid)
      |=> !(lk_valid && lk_vpn == $past(inv_vpn) && lk_hit));
endmodule

bind xc_tlb xc_tlb_chk #(.DEPTH(DEPTH), .VPN_W(xc_pkg::VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_hit(lk_hit), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
  .base_load(base_load), .task_switch(task_switch), .inv_valid(inv_valid),
  .inv_vpn(inv_vpn), .glob_en(glob_en), .valid_q(valid_q), .glob_q(glob_q),
  .lk_hitv(lk_hitv)
);

// File: tb/tb_xc_tlb.sv
`timescale 1ns/1ps
module tb_xc_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [19:0] lk_vpn;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic        lk_writable;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_pfn;
  logic        fill_global;
  logic        fill_writable;
  logic        base_load;
  logic        task_switch;
  logic        inv_valid;
  logic [19:0] inv_vpn;
  logic        glob_en;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  xc_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_writable(lk_writable),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_global(fill_global), .fill_writable(fill_writable),
    .base_load(base_load), .task_switch(task_switch),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .glob_en(glob_en)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0; fill_valid = 0; fill_vpn = '0; fill_pfn = '0;
    fill_global = 0; fill_writable = 0; base_load = 0; task_switch = 0;
    inv_valid = 0; inv_vpn = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // Lookup is combinational: drive and sample away from the edge
  task automatic look(input logic [19:0] vpn, input bit exp_hit,
                      input logic [19:0] exp_pfn, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_vpn = vpn;
    #1;
    check(lk_hit == exp_hit, tag, lk_hit, exp_hit);
    if (exp_hit) check(lk_pfn == exp_pfn, tag, lk_pfn, exp_pfn);
    else         check(lk_pfn == 20'h0, tag, lk_pfn, 0);
    lk_valid = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input bit g, input bit w);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_global = g; fill_writable = w;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic pulse_flush(input bit use_task, input bit ge);
    @(negedge clk);
    glob_en = ge;
    if (use_task) task_switch = 1; else base_load = 1;
    @(negedge clk);
    task_switch = 0; base_load = 0;
  endtask

  task automatic inv_page(input logic [19:0] vpn);
    @(negedge clk);
    inv_valid = 1; inv_vpn = vpn;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    look(20'h00000, 0, 0, "R1 miss vpn0");
    look(20'hFFFFF, 0, 0, "R1 miss vpn max");
    @(negedge clk);
    lk_valid = 0; lk_vpn = 20'h0;
    #1;
    check(lk_hit == 0, "R12 idle no hit", lk_hit, 0);
  endtask

  task automatic t_basic();
    do_reset();
    fill(20'h12345, 20'hABCDE, 0, 1);
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'h12345;
    #1;
    check(lk_hit == 1, "R3 fill visible", lk_hit, 1);
    check(lk_pfn == 20'hABCDE, "R2 pfn", lk_pfn, 20'hABCDE);
    check(lk_writable == 1, "R2 writable", lk_writable, 1);
    lk_valid = 0;
    #1;
    check(lk_hit == 0, "R12 hit needs valid", lk_hit, 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'h12346;
    #1;
    check(lk_hit == 0 && lk_pfn == 0 && lk_writable == 0, "R2 miss zeros",
          {lk_hit, lk_writable, lk_pfn}, 0);
    lk_valid = 0;
  endtask

  task automatic t_overwrite();
    do_reset();
    fill(20'h00050, 20'h11111, 0, 0);
    fill(20'h00050, 20'h22222, 0, 1);
    look(20'h00050, 1, 20'h22222, "R4 overwrite pfn");
    for (int i = 1; i < 8; i++) fill(20'h00060 + 20'(i), 20'h30000 + 20'(i), 0, 0);
    look(20'h00050, 1, 20'h22222, "R4 no duplicate kept slot");
    for (int i = 1; i < 8; i++) look(20'h00060 + 20'(i), 1, 20'h30000 + 20'(i), "R4 others present");
  endtask

  task automatic t_victim();
    do_reset();
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h40000 + 20'(i), 0, 0);
    fill(20'h00108, 20'h40008, 0, 0);
    look(20'h00100, 0, 0, "R6 rr evicts slot0");
    look(20'h00101, 1, 20'h40001, "R6 slot1 kept");
    look(20'h00108, 1, 20'h40008, "R6 new present");
    fill(20'h00109, 20'h40009, 0, 0);
    look(20'h00101, 0, 0, "R6 rr evicts slot1");
    inv_page(20'h00105);
    look(20'h00105, 0, 0, "R10 page removed");
    look(20'h00104, 1, 20'h40004, "R10 neighbour kept");
    fill(20'h0010A, 20'h4000A, 0, 0);
    look(20'h00102, 1, 20'h40002, "R5 free slot used, slot2 kept");
    fill(20'h0010B, 20'h4000B, 0, 0);
    look(20'h00102, 0, 0, "R6 pointer not moved by free fill");
    look(20'h0010A, 1, 20'h4000A, "R5 free-slot entry kept");
    look(20'h00103, 1, 20'h40003, "R6 slot3 kept");
  endtask

  task automatic load_mix();
    fill(20'h00200, 20'h50000, 1, 0);
    fill(20'h00201, 20'h50001, 0, 0);
    fill(20'h00202, 20'h50002, 1, 1);
    fill(20'h00203, 20'h50003, 0, 1);
  endtask

  task automatic t_flush_all();
    do_reset();
    load_mix();
    pulse_flush(0, 0);
    for (int i = 0; i < 4; i++) look(20'h00200 + 20'(i), 0, 0, "R7 all flushed");
  endtask

  task automatic t_flush_glob();
    do_reset();
    load_mix();
    pulse_flush(0, 1);
    look(20'h00200, 1, 20'h50000, "R8 global kept");
    look(20'h00201, 0, 0, "R8 local removed");
    look(20'h00202, 1, 20'h50002, "R8 global kept");
    look(20'h00203, 0, 0, "R8 local removed");
  endtask

  task automatic t_task_switch();
    do_reset();
    load_mix();
    pulse_flush(1, 1);
    look(20'h00200, 1, 20'h50000, "R9 task switch keeps global");
    look(20'h00201, 0, 0, "R9 task switch drops local");
    pulse_flush(1, 0);
    look(20'h00200, 0, 0, "R9 task switch full flush");
    look(20'h00202, 0, 0, "R9 task switch full flush");
  endtask

  task automatic t_inv_global();
    do_reset();
    load_mix();
    glob_en = 1;
    inv_page(20'h00202);
    look(20'h00202, 0, 0, "R10 global page invalidated");
    look(20'h00200, 1, 20'h50000, "R10 other global kept");
    look(20'h00203, 1, 20'h50003, "R10 local kept");
  endtask

  task automatic t_same_cycle();
    do_reset();
    load_mix();
    @(negedge clk);
    glob_en = 0; base_load = 1;
    fill_valid = 1; fill_vpn = 20'h00777; fill_pfn = 20'h77777; fill_global = 0; fill_writable = 0;
    @(negedge clk);
    base_load = 0; fill_valid = 0;
    look(20'h00777, 1, 20'h77777, "R11 fill survives flush");
    look(20'h00200, 0, 0, "R11 flush still applied");
    fill(20'h00201, 20'h60001, 0, 0);
    @(negedge clk);
    inv_valid = 1; inv_vpn = 20'h00201;
    fill_valid = 1; fill_vpn = 20'h00201; fill_pfn = 20'h6ABCD;
    @(negedge clk);
    inv_valid = 0; fill_valid = 0;
    look(20'h00201, 1, 20'h6ABCD, "R11 refill after invalidate");
    look(20'h00777, 1, 20'h77777, "R11 unrelated entry kept");
  endtask

  initial begin
    #(20.0 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs();
    glob_en = 0;
    rst_n = 0;
    t_reset_state();
    t_basic();
    t_overwrite();
    t_victim();
    t_flush_all();
    t_flush_glob();
    t_task_switch();
    t_inv_global();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule